// File: doc/BRIEF.md
# Watchdog and Alarm Countdown Timer

This block is a 24-bit down-counter with two uses, picked by a mode bit in a byte-wide control register. In the periodic mode it counts down once per second and, instead of reaching zero, reloads from a preset and keeps going. In the one-shot mode it counts down at the rate of a 4096 Hz tick. On expiry it stops at zero, raises an alarm flag and fires a pulse of 1024 ticks (a quarter second). A steering bit sends that pulse to either the reset output or the interrupt output. The 1 Hz rate comes from dividing the 4096 Hz tick input inside the block.

Software reaches the block over a simple register bus: write and read strobes, a 3-bit address, write data and combinational read data. Any access to one of the three counter bytes, read or write, reloads the counter from the preset. A watchdog is therefore serviced just by reading a counter byte. When the counter is disabled, the three bytes act as plain storage.

Top module: `wdt_alarm_timer`

## Requirements
- R1: After reset the control register reads 0x06, the status register reads 0x00, the counter and preset read 0, and rstOut and intOut are low.
- R2: While control bit 6 (enable) is 0 the counter never changes except on reload, and each counter byte reads back the last value written to it.
- R3: With enable=1 and control bit 5 (mode) = 0 the counter decrements once per 4096 input ticks; when it is at 1 and a decrement is due it loads the preset instead of reaching zero, so it never reads 0 for a nonzero preset, and no flag or pulse results.
- R4: With enable=1 and mode=1 the counter decrements on every input tick; the decrement from 1 to 0 sets the alarm flag (status address 4, bit 0), and the counter then holds at 0.
- R5: A read or write strobe to address 0, 1 or 2 (counter bytes, least significant first) reloads the counter from the preset in the next cycle; a write first replaces that byte of the preset.
- R6: An expiry in mode 1 starts a pulse lasting exactly 1024 input ticks, driven on rstOut when control bit 3 (steer) was 0 at expiry and on intOut when it was 1; the chosen pin is held for the whole pulse.
- R7: intOut is also high whenever the alarm flag is 1, control bit 0 (interrupt enable) is 1 and steer is 1.
- R8: Clearing interrupt enable while a pulse is on intOut does not shorten that pulse.
- R9: Writing status address 4 with bit 0 = 0 clears the alarm flag; writing bit 0 = 1 leaves it unchanged; an expiry in the same cycle wins.
- R10: A preset of zero with the counter enabled keeps the counter at 0 with no expiry, no flag and no pulse.
- R11: The control register is at address 3 and stores all 8 bits; addresses 5 to 7 read as 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick4k | input | 1 | One-cycle strobe at 4096 Hz |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data of the addressed register (combinational) |
| alarmFlag | output | 1 | Alarm flag |
| rstOut | output | 1 | Reset pulse output |
| intOut | output | 1 | Interrupt output |

## Verification
The bench goes after the decrement from 1, which is the single point where the modes split. A design that compared against zero instead of one would show 0 for a tick in periodic mode, or never raise the flag in one-shot mode. The bench services the watchdog only through reads, so a reload that triggered on writes alone would let it expire. It counts every cycle of the pulse, catching an off-by-one in the 1024-tick window. It clears interrupt enable in the middle of an interrupt pulse, where gating the pulse with that bit would cut the pulse short. A zero preset with the counter enabled must not wrap to all ones and later expire.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Number of counter bytes; the counter is 8*CNT_BYTES bits wide.
  parameter int CNT_BYTES = 3;

  // Strobes from the control section to the count datapath.
  typedef struct packed {
    logic                 reload;    // load counter from (updated) preset
    logic [CNT_BYTES-1:0] byteWr;    // replace one preset byte
    logic [7:0]           wrByte;    // data for byteWr
    logic                 decEn;     // a decrement is due this cycle
    logic                 wrapMode;  // 1: reload at expiry, 0: stop at zero
  } dpStrobe_t;

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strb,
  output logic [8*CNT_BYTES-1:0] cntQ,
  output logic                   zeroEvt
);

  localparam int W = 8 * CNT_BYTES;

  logic [W-1:0] presetQ;
  logic [W-1:0] presetD;

  // One register per preset byte.
  for (genvar b = 0; b < CNT_BYTES; b++) begin : g_preset
    assign presetD[8*b +: 8] = strb.byteWr[b] ? strb.wrByte : presetQ[8*b +: 8];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) presetQ[8*b +: 8] <= '0;
      else       presetQ[8*b +: 8] <= presetD[8*b +: 8];
    end
  end

  // Expiry: a due decrement from one, not masked by a reload.
  assign zeroEvt = !strb.reload && strb.decEn && (cntQ == W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strb.reload) begin
      cntQ <= presetD;
    end else if (strb.decEn && (cntQ != '0)) begin
      if (cntQ == W'(1)) cntQ <= strb.wrapMode ? presetQ : '0;
      else               cntQ <= cntQ - W'(1);
    end
  end

  // R2: without reload or due decrement the count holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.reload && !strb.decEn) |=> $stable(cntQ));

  // R5: after a reload the counter equals the stored preset
  p_reload_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> (cntQ == presetQ));

  // R10: an idle zero count stays zero until reloaded
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((cntQ == '0) && !strb.reload) |=> (cntQ == '0));

endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int PULSE_W = 10,
  parameter int ADDR_W  = 3
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tick4k,
  input  logic                   busWr,
  input  logic                   busRd,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [7:0]             busWdata,
  input  logic [8*CNT_BYTES-1:0] cntQ,
  input  logic                   zeroEvt,
  output dpStrobe_t              strb,
  output logic [7:0]             busRdata,
  output logic                   alarmFlag,
  output logic                   rstOut,
  output logic                   intOut
);

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(CNT_BYTES);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(CNT_BYTES + 1);
  localparam logic [7:0]        CTRL_RST = 8'h06;
  localparam int B_EN    = 6;
  localparam int B_MODE  = 5;
  localparam int B_STEER = 3;
  localparam int B_AIE   = 0;

  logic [7:0]         ctrlQ;
  logic [DIV_W-1:0]   divCnt;
  logic               tick1;
  logic               isCnt;
  logic               expire;
  logic               pulseOn;
  logic               pulseSteer;
  logic [PULSE_W-1:0] pulseCnt;

  assign isCnt  = busAddr < A_CTRL;
  assign tick1  = tick4k && (divCnt == '1);
  assign expire = zeroEvt && ctrlQ[B_MODE];

  // Strobes toward the datapath.
  always_comb begin
    strb.reload   = isCnt && (busWr || busRd);
    strb.wrByte   = busWdata;
    strb.decEn    = ctrlQ[B_EN] && (ctrlQ[B_MODE] ? tick4k : tick1);
    strb.wrapMode = !ctrlQ[B_MODE];
    for (int b = 0; b < CNT_BYTES; b++)
      strb.byteWr[b] = busWr && (busAddr == ADDR_W'(b));
  end

  // Read mux.
  always_comb begin
    busRdata = '0;
    for (int b = 0; b < CNT_BYTES; b++)
      if (busAddr == ADDR_W'(b)) busRdata = cntQ[8*b +: 8];
    if (busAddr == A_CTRL) busRdata = ctrlQ;
    if (busAddr == A_STAT) busRdata = {7'b0, alarmFlag};
  end

  // Control register and 1 Hz divider.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ  <= CTRL_RST;
      divCnt <= '0;
    end else begin
      if (busWr && (busAddr == A_CTRL)) ctrlQ <= busWdata;
      if (tick4k) divCnt <= divCnt + DIV_W'(1);
    end
  end

  // Alarm flag: expiry wins over a clearing write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      alarmFlag <= 1'b0;
    else if (expire)
      alarmFlag <= 1'b1;
    else if (busWr && (busAddr == A_STAT) && !busWdata[0])
      alarmFlag <= 1'b0;
  end

  // Expiry pulse generator, steering captured at start.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseOn    <= 1'b0;
      pulseSteer <= 1'b0;
      pulseCnt   <= '0;
    end else if (expire) begin
      pulseOn    <= 1'b1;
      pulseSteer <= ctrlQ[B_STEER];
      pulseCnt   <= '0;
    end else if (pulseOn && tick4k) begin
      if (pulseCnt == '1) pulseOn  <= 1'b0;
      else                pulseCnt <= pulseCnt + PULSE_W'(1);
    end
  end

  assign rstOut = pulseOn && !pulseSteer;
  assign intOut = (pulseOn && pulseSteer) ||
                  (alarmFlag && ctrlQ[B_AIE] && ctrlQ[B_STEER]);

  // R4: a one-shot expiry raises the flag and starts the pulse
  p_flag_on_expiry_r4: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (alarmFlag && pulseOn));

  // R6: a pulse only ends on the tick that completes its window
  p_pulse_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulseOn) |-> ($past(pulseCnt) == {PULSE_W{1'b1}} && $past(tick4k)));

  // R8: an interrupt pulse keeps intOut high whatever the control writes
  p_aie_keeps_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pulseOn && pulseSteer && !tick4k) |=> intOut);

  // R9: a clearing status write without expiry drops the flag
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && (busAddr == A_STAT) && !busWdata[0] && !expire) |=> !alarmFlag);

endmodule

// File: rtl/wdt_alarm_timer.sv
module wdt_alarm_timer
  import wdt_pkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int PULSE_W = 10,
  parameter int ADDR_W  = 3
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick4k,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              alarmFlag,
  output logic              rstOut,
  output logic              intOut
);

  dpStrobe_t              strb;
  logic [8*CNT_BYTES-1:0] cntQ;
  logic                   zeroEvt;

  wdt_control #(
    .DIV_W  (DIV_W),
    .PULSE_W(PULSE_W),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick4k   (tick4k),
    .busWr    (busWr),
    .busRd    (busRd),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .cntQ     (cntQ),
    .zeroEvt  (zeroEvt),
    .strb     (strb),
    .busRdata (busRdata),
    .alarmFlag(alarmFlag),
    .rstOut   (rstOut),
    .intOut   (intOut)
  );

  wdt_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .cntQ   (cntQ),
    .zeroEvt(zeroEvt)
  );

endmodule

// File: tb/sim_wdt_alarm_timer.sv
module sim_wdt_alarm_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick4k = 1'b0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [2:0] busAddr = 3'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       alarmFlag, rstOut, intOut;

  int nTests = 0;
  int nFail  = 0;
  int cycles = 0;
  int tickPh = 0;
  bit done   = 1'b0;

  // Behavioural reference state
  int mCtrl = 6, mPreset = 0, mCnt = 0, mFlag = 0, mDiv = 0, mLeft = 0, mSteer = 0;

  wdt_alarm_timer u0 (
    .clk(clk), .rstN(rstN), .tick4k(tick4k), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .alarmFlag(alarmFlag), .rstOut(rstOut), .intOut(intOut)
  );

  always #10 clk = ~clk;

  // 4096 Hz tick stand-in: one strobe every 4 clocks
  always @(negedge clk) begin
    tickPh = (tickPh + 1) % 4;
    tick4k = (tickPh == 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int expRd(input int a);
    if (a < 3) return (mCnt >> (8 * a)) & 255;
    if (a == 3) return mCtrl;
    if (a == 4) return mFlag;
    return 0;
  endfunction

  // Reference model update on each rising edge
  always @(posedge clk) begin
    int acc, pn, t1, dec, zero, m, sh;
    if (!rstN) begin
      mCtrl = 6; mPreset = 0; mCnt = 0; mFlag = 0; mDiv = 0; mLeft = 0; mSteer = 0;
    end else begin
      sh  = 8 * int'(busAddr);
      acc = (busWr || busRd) && (busAddr < 3);
      pn  = mPreset;
      if (busWr && busAddr < 3) pn = (pn & ~(255 << sh)) | (int'(busWdata) << sh);
      t1 = tick4k && (mDiv == 4095);
      if (tick4k) mDiv = (mDiv == 4095) ? 0 : mDiv + 1;
      m   = (mCtrl >> 5) & 1;
      dec = ((mCtrl >> 6) & 1) && (m ? tick4k : t1);
      zero = 0;
      if (acc) mCnt = pn;
      else if (dec && mCnt != 0) begin
        if (mCnt == 1) begin zero = 1; mCnt = m ? 0 : mPreset; end
        else mCnt = mCnt - 1;
      end
      if (zero && m) begin mLeft = 1024; mSteer = (mCtrl >> 3) & 1; end
      else if (mLeft > 0 && tick4k) mLeft = mLeft - 1;
      if (zero && m) mFlag = 1;
      else if (busWr && busAddr == 4 && !busWdata[0]) mFlag = 0;
      if (busWr && busAddr == 3) mCtrl = int'(busWdata);
      mPreset = pn;
    end
  end

  // Compare every cycle, mid-cycle after inputs settle
  always @(posedge clk) begin
    #15;
    if (rstN && !done) begin
      chk("R6 rstOut", int'(rstOut), (mLeft > 0 && mSteer == 0) ? 1 : 0);
      chk("R7 intOut", int'(intOut),
          ((mLeft > 0 && mSteer == 1) || (mFlag == 1 && (mCtrl & 1) && ((mCtrl >> 3) & 1))) ? 1 : 0);
      chk("R4 alarmFlag", int'(alarmFlag), mFlag);
      chk("R11 busRdata", int'(busRdata), expRd(int'(busAddr)));
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      nFail++;
      $display("FAIL watchdog act=%0d exp=<190000", cycles);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  task automatic wrReg(input int a, input int d);
    @(negedge clk);
    busWr = 1'b1; busAddr = 3'(a); busWdata = 8'(d);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdReg(input int a, output int v);
    @(negedge clk);
    busRd = 1'b1; busAddr = 3'(a);
    #5 v = int'(busRdata);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic peek(input int a, output int v);
    @(negedge clk);
    busAddr = 3'(a);
    #5 v = int'(busRdata);
  endtask

  task automatic waitTicks(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  initial begin
    int v, len, bad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    rdReg(3, v); chk("R1 ctrl", v, 8'h06);
    rdReg(4, v); chk("R1 status", v, 0);
    rdReg(0, v); chk("R1 count", v, 0);
    chk("R1 rstOut", int'(rstOut), 0);
    chk("R1 intOut", int'(intOut), 0);

    // R2/R5: storage while disabled
    wrReg(0, 8'h56); wrReg(1, 8'h34); wrReg(2, 8'h12);
    waitTicks(5000);
    rdReg(0, v); chk("R2 byte0", v, 8'h56);
    rdReg(1, v); chk("R2 byte1", v, 8'h34);
    rdReg(2, v); chk("R2 byte2", v, 8'h12);

    // R11: unmapped address
    wrReg(6, 8'hFF);
    rdReg(6, v); chk("R11 unmapped", v, 0);
    rdReg(3, v); chk("R11 ctrl kept", v, 8'h06);

    // R4/R6: one-shot expiry steered to rstOut, pulse length
    wrReg(0, 5); wrReg(1, 0); wrReg(2, 0);
    wrReg(3, 8'h60);
    len = 0;
    while (!rstOut && len < 200) begin @(negedge clk); len++; end
    chk("R4 flag set", int'(alarmFlag), 1);
    chk("R6 on intOut", int'(intOut), 0);
    len = 0;
    while (rstOut) begin len++; @(negedge clk); end
    chk("R6 pulse cycles", len, 4096);
    peek(0, v); chk("R4 held at zero", v, 0);

    // R9: flag clearing
    wrReg(4, 1); #5 chk("R9 write one", int'(alarmFlag), 1);
    wrReg(4, 0); #5 chk("R9 write zero", int'(alarmFlag), 0);

    // R5: servicing by reads
    wrReg(0, 20);
    for (int i = 0; i < 10; i++) begin waitTicks(10); rdReg(1, v); end
    chk("R5 serviced no flag", int'(alarmFlag), 0);
    waitTicks(25);
    chk("R5 unserviced flag", int'(alarmFlag), 1);
    waitTicks(1100);
    wrReg(4, 0);

    // R6/R7/R8: interrupt steering
    wrReg(3, 8'h69);
    rdReg(0, v);
    waitTicks(25);
    chk("R6 int pulse", int'(intOut), 1);
    chk("R6 rst quiet", int'(rstOut), 0);
    wrReg(3, 8'h68);
    #5 chk("R8 pulse kept", int'(intOut), 1);
    waitTicks(1100);
    chk("R8 pulse ended", int'(intOut), 0);
    wrReg(3, 8'h69);
    #5 chk("R7 flag interrupt", int'(intOut), 1);
    wrReg(4, 0);
    #5 chk("R7 cleared", int'(intOut), 0);

    // R10: zero preset while enabled
    wrReg(0, 0);
    waitTicks(50);
    chk("R10 no flag", int'(alarmFlag), 0);
    peek(0, v); chk("R10 count", v, 0);

    // R3: periodic mode never shows zero
    wrReg(3, 8'h40);
    wrReg(0, 2);
    busAddr = 3'd0;
    bad = 0;
    repeat (3 * 4096 * 4) begin
      @(negedge clk);
      #5 if (busRdata == 8'd0 || alarmFlag || rstOut) bad++;
    end
    chk("R3 no zero", bad, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule